// File: doc/BRIEF.md
# Cascadable LCD Segment Row Loader

This block collects one row of display data for a column-driving LCD segment driver and holds it steady while the panel shows it. Data arrives on a shift clock whose falling edges are sampled. Each edge carries either a single bit or a 4-bit nibble, chosen by a mode input. Every accepted edge fills the next free column or columns, starting at column 0 (the first segment output). A falling edge on the load strobe copies the collected row into an output latch and clears the fill position, so the next row starts again at column 0.

Several loaders can share one data bus. Each one accepts data only while its active-low enable input is low. Its active-low enable output goes low once every column has been filled, which enables the next loader in the chain. For each column the block produces a registered 2-bit drive-level code. The code is formed from the latched bit, the frame alternation input and an active-low blanking input. All of these inputs are sampled on a single system clock.

Top module: `seg_row_loader`

## Requirements
- R1: While `rst` is high, every code in `seg_code` is 00 and `ce_out_n` is high. Reset also clears the latched row, so with blanking off and `frame_alt` low every column then shows code 11.
- R2: In serial mode (`par_mode` low), each accepted falling edge of `shift_clk` stores `ser_din` in the next free column. Columns fill in ascending order, starting at column 0.
- R3: In nibble mode (`par_mode` high), each accepted falling edge stores `par_din[0]`, `par_din[1]`, `par_din[2]` and `ser_din` into the next four free columns, in ascending order. `ser_din` goes to the highest of the four, and the nibble starts at whatever column the fill position holds.
- R4: While `ce_in_n` is high, falling edges of `shift_clk` neither store data nor advance the fill position.
- R5: `ce_out_n` goes low on the clock after the edge that fills the last column. That takes NCOL edges in serial mode or NCOL/4 in nibble mode. Further edges are then ignored until the next load.
- R6: A falling edge of `load_strb` copies the row into the output latch, clears the fill position and returns `ce_out_n` high. A shift-clock falling edge seen in the same cycle is ignored.
- R7: With `blank_n` high, a column with latched 1 shows 01 when `frame_alt` is 1 and 00 when it is 0. A column with latched 0 shows 10 when `frame_alt` is 1 and 11 when it is 0. The codes are 00 = V1, 01 = VEE, 10 = V3, 11 = V4.
- R8: With `blank_n` low, every column shows 00 whatever the data or `frame_alt`.
- R9: Only a high-to-low transition of `shift_clk` acts. Holding it low for several cycles stores one column (or one nibble) only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1 selects nibble input, 0 selects serial input |
| ser_din | input | 1 | Serial data bit, or the top bit of the nibble |
| par_din | input | 3 | Lower three bits of the nibble |
| shift_clk | input | 1 | Data clock, acts on its falling edge |
| load_strb | input | 1 | Row load strobe, acts on its falling edge |
| ce_in_n | input | 1 | Active-low enable from the previous loader |
| ce_out_n | output | 1 | Active-low enable to the next loader, low when full |
| frame_alt | input | 1 | Frame alternation signal |
| blank_n | input | 1 | Active-low display blanking |
| seg_code | output | 2*NCOL | Drive-level code per column, column i at bits 2i+1:2i |

## Verification
The bench builds two loaders with NCOL set to 8 and chains the first one's enable output into the second one's enable input. With only eight columns, the fill boundary, the saturation after full, the hand-off to the second device and a nibble that starts at an unaligned column all take a few dozen clocks. Every column's code can be compared against a requirement-level model of both rows. The default of 80 columns uses the same generated per-column logic and is only elaborated.

// File: rtl/seg_row_pkg.sv
package seg_row_pkg;

  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_VEE = 2'b01,
    LVL_V3  = 2'b10,
    LVL_V4  = 2'b11
  } drive_lvl_e;

  function automatic drive_lvl_e drive_code(input logic dat, input logic alt, input logic on);
    drive_lvl_e lvl;
    if (!on)
      lvl = LVL_V1;
    else if (dat)
      lvl = alt ? LVL_VEE : LVL_V1;
    else
      lvl = alt ? LVL_V3 : LVL_V4;
    return lvl;
  endfunction

endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= din;
  end

  assign fall = prev_q & ~din;
endmodule

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl #(
  parameter int NCOL = 80,
  parameter int NIB  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cp_fall,
  input  logic            load_fall,
  input  logic            ce_in_n,
  input  logic            par_mode,
  input  logic [NIB-1:0]  nib,
  output logic [NCOL-1:0] row,
  output logic            ce_out_n
);
  localparam int CNT_W = $clog2(NCOL + 1);
  localparam int NIB_W = $clog2(NIB);
  localparam logic [CNT_W:0] FULL_V = (CNT_W+1)'(NCOL);
  localparam logic [CNT_W:0] NIB_V  = (CNT_W+1)'(NIB);

  logic [CNT_W:0]  cnt_q;
  logic [CNT_W:0]  cnt_nxt;
  logic [CNT_W:0]  sum;
  logic            full_q;
  logic            accept;
  logic [NCOL-1:0] wr_v;
  logic [NCOL-1:0] dat_v;

  assign accept = cp_fall & ~load_fall & ~ce_in_n & ~full_q;

  always_comb begin
    sum     = cnt_q + (par_mode ? NIB_V : (CNT_W+1)'(1));
    cnt_nxt = (sum > FULL_V) ? FULL_V : sum;
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    localparam logic [CNT_W:0] IDX = (CNT_W+1)'(i);
    logic [CNT_W:0] off;
    logic           hit;
    assign off = IDX - cnt_q;
    assign hit = par_mode ? ((IDX >= cnt_q) && (IDX < cnt_q + NIB_V)) : (IDX == cnt_q);
    assign wr_v[i]  = accept & hit;
    assign dat_v[i] = par_mode ? nib[off[NIB_W-1:0]] : nib[NIB-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      row    <= '0;
    end else if (load_fall) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      cnt_q  <= cnt_nxt;
      full_q <= (cnt_nxt == FULL_V);
      row    <= (row & ~wr_v) | (dat_v & wr_v);
    end
  end

  assign ce_out_n = ~full_q;
endmodule

// File: rtl/seg_level_out.sv
module seg_level_out
  import seg_row_pkg::*;
#(
  parameter int NCOL = 80
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_fall,
  input  logic [NCOL-1:0]   row,
  input  logic              frame_alt,
  input  logic              blank_n,
  output logic [2*NCOL-1:0] seg_code
);
  logic [NCOL-1:0]   latch_q;
  logic [2*NCOL-1:0] code_nxt;

  always_ff @(posedge clk) begin
    if (rst)            latch_q <= '0;
    else if (load_fall) latch_q <= row;
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_map
    assign code_nxt[2*i +: 2] = drive_code(latch_q[i], frame_alt, blank_n);
  end

  always_ff @(posedge clk) begin
    if (rst) seg_code <= '0;
    else     seg_code <= code_nxt;
  end
endmodule

// File: rtl/seg_row_loader.sv
module seg_row_loader #(
  parameter int NCOL = 80,
  parameter int NIB  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic              ser_din,
  input  logic [NIB-2:0]    par_din,
  input  logic              shift_clk,
  input  logic              load_strb,
  input  logic              ce_in_n,
  output logic              ce_out_n,
  input  logic              frame_alt,
  input  logic              blank_n,
  output logic [2*NCOL-1:0] seg_code
);
  logic            cp_fall;
  logic            load_fall;
  logic [NCOL-1:0] row;

  seg_fall_detect u_cp_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (shift_clk),
    .fall (cp_fall)
  );

  seg_fall_detect u_load_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (load_strb),
    .fall (load_fall)
  );

  seg_fill_ctrl #(.NCOL(NCOL), .NIB(NIB)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .cp_fall   (cp_fall),
    .load_fall (load_fall),
    .ce_in_n   (ce_in_n),
    .par_mode  (par_mode),
    .nib       ({ser_din, par_din}),
    .row       (row),
    .ce_out_n  (ce_out_n)
  );

  seg_level_out #(.NCOL(NCOL)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load_fall (load_fall),
    .row       (row),
    .frame_alt (frame_alt),
    .blank_n   (blank_n),
    .seg_code  (seg_code)
  );
endmodule

// File: rtl/seg_row_loader_chk.sv
module seg_row_loader_chk #(
  parameter int NCOL = 80
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_in_n,
  input logic              load_strb,
  input logic              blank_n,
  input logic              ce_out_n,
  input logic [2*NCOL-1:0] seg_code
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ce_out_n && seg_code == '0)); // R1

  AST_CE_BLOCKS_FILL: assert property (@(posedge clk) disable iff (rst)
    (ce_in_n && load_strb) |=> $stable(ce_out_n)); // R4

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ce_out_n && load_strb) |=> !ce_out_n); // R5

  AST_LOAD_REARMS: assert property (@(posedge clk) disable iff (rst)
    $fell(load_strb) |=> ce_out_n); // R6

  AST_BLANK_V1: assert property (@(posedge clk) disable iff (rst)
    !blank_n |=> (seg_code == '0)); // R8
endmodule

bind seg_row_loader seg_row_loader_chk #(.NCOL(NCOL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_in_n   (ce_in_n),
  .load_strb (load_strb),
  .blank_n   (blank_n),
  .ce_out_n  (ce_out_n),
  .seg_code  (seg_code)
);

// File: tb/seg_row_loader_bench.sv
module seg_row_loader_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic par_mode = 1'b0, ser_din = 1'b0, shift_clk = 1'b1, load_strb = 1'b1;
  logic [2:0] par_din = 3'b000;
  logic ce_n = 1'b0, frame_alt = 1'b0, blank_n = 1'b1;
  logic ce_a, ce_b;
  logic [2*N-1:0] code_a, code_b;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] row_a = '0, row_b = '0, lat_a = '0, lat_b = '0;
  int cnt_a = 0, cnt_b = 0;

  always #4 clk = ~clk;

  seg_row_loader #(.NCOL(N)) u_seg_row_loader (
    .clk(clk), .rst(rst), .par_mode(par_mode), .ser_din(ser_din), .par_din(par_din),
    .shift_clk(shift_clk), .load_strb(load_strb), .ce_in_n(ce_n), .ce_out_n(ce_a),
    .frame_alt(frame_alt), .blank_n(blank_n), .seg_code(code_a));

  seg_row_loader #(.NCOL(N)) u_seg_row_loader_nxt (
    .clk(clk), .rst(rst), .par_mode(par_mode), .ser_din(ser_din), .par_din(par_din),
    .shift_clk(shift_clk), .load_strb(load_strb), .ce_in_n(ce_a), .ce_out_n(ce_b),
    .frame_alt(frame_alt), .blank_n(blank_n), .seg_code(code_b));

  function automatic logic [1:0] lvl(input logic d, input logic m, input logic on);
    if (!on) return 2'b00;
    case ({d, m})
      2'b11:   return 2'b01;
      2'b10:   return 2'b00;
      2'b01:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [2*N-1:0] exp_codes(input logic [N-1:0] lat);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = lvl(lat[i], frame_alt, blank_n);
    return v;
  endfunction

  task automatic check(input string tag, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    repeat (3) @(negedge clk);
    check({tag, " dev0 codes"}, code_a, exp_codes(lat_a));
    check({tag, " dev1 codes"}, code_b, exp_codes(lat_b));
    check({tag, " dev0 enable"}, {{(2*N-1){1'b0}}, ce_a}, {{(2*N-1){1'b0}}, cnt_a != N});
    check({tag, " dev1 enable"}, {{(2*N-1){1'b0}}, ce_b}, {{(2*N-1){1'b0}}, cnt_b != N});
  endtask

  function automatic void model_write(inout logic [N-1:0] row, inout int cnt, input logic [3:0] nib);
    if (!par_mode) begin
      row[cnt] = nib[3];
      cnt++;
    end else begin
      for (int k = 0; k < 4; k++) if (cnt + k < N) row[cnt + k] = nib[k];
      cnt = (cnt + 4 > N) ? N : cnt + 4;
    end
  endfunction

  task automatic pulse(input logic [3:0] nib, input int low_cycles);
    @(negedge clk);
    ser_din = nib[3];
    par_din = nib[2:0];
    shift_clk = 1'b0;
    repeat (low_cycles) @(negedge clk);
    shift_clk = 1'b1;
    if (cnt_a == N) begin
      if (cnt_b < N) model_write(row_b, cnt_b, nib);
    end else if (!ce_n) begin
      model_write(row_a, cnt_a, nib);
    end
  endtask

  task automatic load_row(input logic with_cp);
    @(negedge clk);
    load_strb = 1'b0;
    if (with_cp) shift_clk = 1'b0;
    @(negedge clk);
    load_strb = 1'b1;
    shift_clk = 1'b1;
    lat_a = row_a;
    lat_b = row_b;
    cnt_a = 0;
    cnt_b = 0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset codes", code_a, '0);
    check("R1 reset enable", {{(2*N-1){1'b0}}, ce_a}, {{(2*N-1){1'b0}}, 1'b1});
    rst = 1'b0;
    check_all("R1 cleared latch");
  endtask

  task automatic t_serial;
    logic [N-1:0] pat = 8'b1011_0010;
    par_mode = 1'b0;
    for (int i = 0; i < N; i++) pulse({pat[i], 3'b000}, 1);
    check_all("R2 R5 serial full");
    load_row(1'b0);
    check_all("R2 R6 serial load");
  endtask

  task automatic t_chain;
    logic [2*N-1:0] pat = 16'hC3A5;
    par_mode = 1'b0;
    for (int i = 0; i < 2*N; i++) pulse({pat[i], 3'b000}, 1);
    check_all("R5 hand-off full");
    pulse(4'b1000, 1);
    check_all("R5 both full ignore");
    load_row(1'b0);
    check_all("R5 R6 chain load");
  endtask

  task automatic t_parallel;
    par_mode = 1'b1;
    pulse(4'hA, 1);
    pulse(4'h5, 1);
    check_all("R3 R5 nibble full");
    load_row(1'b0);
    check_all("R3 nibble load");
  endtask

  task automatic t_mixed;
    par_mode = 1'b0;
    pulse(4'b1000, 1);
    pulse(4'b1000, 1);
    par_mode = 1'b1;
    pulse(4'b1001, 1);
    par_mode = 1'b0;
    pulse(4'b0000, 1);
    pulse(4'b1000, 1);
    check_all("R3 unaligned nibble full");
    load_row(1'b0);
    check_all("R3 unaligned nibble load");
  endtask

  task automatic t_ignore_ce;
    par_mode = 1'b0;
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) pulse(4'b1000, 1);
    check_all("R4 disabled no advance");
    ce_n = 1'b0;
    for (int i = 0; i < N; i++) pulse({i[0], 3'b000}, 1);
    load_row(1'b0);
    check_all("R4 data after enable");
  endtask

  task automatic t_hold_low;
    par_mode = 1'b0;
    pulse(4'b0000, 5);
    pulse(4'b1000, 4);
    check_all("R9 held low one column");
    for (int i = 0; i < N - 2; i++) pulse(4'b1000, 1);
    load_row(1'b0);
    check_all("R9 held low load");
  endtask

  task automatic t_collide;
    par_mode = 1'b0;
    for (int i = 0; i < 3; i++) pulse(4'b0000, 1);
    load_row(1'b1);
    check_all("R6 load beats clock");
  endtask

  task automatic t_levels;
    frame_alt = 1'b1;
    check_all("R7 alternation high");
    frame_alt = 1'b0;
    check_all("R7 alternation low");
    blank_n = 1'b0;
    check_all("R8 blanked");
    frame_alt = 1'b1;
    check_all("R8 blanked alt");
    blank_n = 1'b1;
    check_all("R7 unblanked");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_serial;
    t_chain;
    t_parallel;
    t_mixed;
    t_ignore_ce;
    t_hold_low;
    t_collide;
    t_levels;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule